// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block holds a bank of eight general registers that share one internal data bus. Each clock interval the controller applies a 5-bit control word. The word either puts one register onto the bus or writes the bus value into one register. The bus value is held in a bus latch, so a value put on the bus in one interval can be written into a register in the next interval. A register-to-register copy therefore takes two control words in a row: first a drive step that names the source, then a load step that names the destination.

During a load step an external data input can be placed on the bus in place of the latched value. This is how outside data enters the bank. The latched bus value is always visible on an observation output, so reading any register takes one drive step. A control word with both direction flags set is illegal. The block refuses it and raises an error flag for one cycle.

Top module: `rtx_bus_datapath`

## Requirements
- R1: A synchronous active-low reset clears all eight registers and the bus latch to zero. It also clears the error flag, so `bus_obs` is 0 and `err_illegal` is 0 after reset.
- R2: The control word layout is fixed. Bit 4 is the load flag, bit 3 is the drive flag, and bits 2:0 select a register from r0 to r7.
- R3: In a drive step (`ctrl_word` = 01sss), the bus latch takes the value of register sss at the clock edge that ends the interval. That value appears on `bus_obs` after the edge. No register changes.
- R4: In a load step without injection (`ctrl_word` = 10sss, `inj_en` = 0), register sss takes the current bus latch value. The bus latch and all other registers keep their values.
- R5: In a load step with injection (`ctrl_word` = 10sss, `inj_en` = 1), register sss and the bus latch both take `ext_bus_in`.
- R6: A drive step on register s followed at once by a load step on register d copies register s into register d. For example, 01001 then 10101 copies r1 into r5.
- R7: An idle word (bits 4:3 = 00) changes no register and leaves the bus latch unchanged, whatever `inj_en` and `ext_bus_in` are.
- R8: An illegal word (bits 4:3 = 11) changes no register and leaves the bus latch unchanged. `err_illegal` is 1 in the cycle after such a word and 0 after any legal word.
- R9: `inj_en` and `ext_bus_in` have an effect only during a load step. During a drive step the latch takes the register value and not the external value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one control interval per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 5 | {load, drive, select[2:0]} control word |
| inj_en | input | 1 | During a load step, selects `ext_bus_in` as the bus source |
| ext_bus_in | input | 16 | External data injected onto the bus |
| bus_obs | output | 16 | Bus latch value |
| err_illegal | output | 1 | Set in the cycle after a word with both flags set |

## Verification
First, injected loads write a distinct arithmetic pattern into every register, and a drive step reads each one back. This separates a select-decode fault from a storage fault. Second, all 64 source and destination pairs are moved with garbage held on the external input. A correct copy rules out both the wrong source and a leak of the injection path. Third, idle and illegal words are applied with injection enabled, and each register is read back afterwards. This shows that those words leave the state untouched and that the error flag lasts only one cycle.

// File: rtl/rtx_pkg.sv
// Package: shared operation type for the register transfer datapath.
// Assumes a control word of {load, drive, select}.
package rtx_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_DRIVE = 2'd1,
        OP_LOAD  = 2'd2,
        OP_BAD   = 2'd3
    } rtx_op_e;
endpackage

// File: rtl/rtx_ctrl_decode.sv
// Control decoder: splits the control word into an operation and a select.
// It also registers the illegal-code flag.
// Assumes that the word is stable for the whole interval.
module rtx_ctrl_decode
    import rtx_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int CW_W = SEL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW_W-1:0]  ctrl_word,
    output rtx_op_e          op,
    output logic [SEL_W-1:0] sel,
    output logic             err_q
);
    logic load_f;
    logic drive_f;

    // Purpose: field split and operation decode.
    always_comb begin
        load_f  = ctrl_word[CW_W-1];
        drive_f = ctrl_word[CW_W-2];
        sel     = ctrl_word[SEL_W-1:0];
        unique case ({load_f, drive_f})
            2'b00:   op = OP_IDLE;
            2'b01:   op = OP_DRIVE;
            2'b10:   op = OP_LOAD;
            default: op = OP_BAD;
        endcase
    end

    // Purpose: one-cycle error flag after an illegal word.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (op == OP_BAD);
    end
endmodule

// File: rtl/rtx_reg_bank.sv
// Register bank: NUM_REGS entries with one write port and one read port.
// Both ports use the same select, because only one transfer happens per interval.
module rtx_reg_bank #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Purpose: storage for entry g; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (sel == SEL_W'(g)))
                regs[g] <= wr_data;
        end
    end

    // Purpose: read multiplexer that puts the selected entry on the bus.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (sel == SEL_W'(i)) rd_data = regs[i];
    end
endmodule

// File: rtl/rtx_bus_latch.sv
// Bus latch: holds the bus value between intervals.
// It takes the register read data in a drive step and the external input in an injected load step.
module rtx_bus_latch
    import rtx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rtx_op_e           op,
    input  logic              inj_en,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] ext_bus_in,
    output logic [DATA_W-1:0] latch_q,
    output logic [DATA_W-1:0] wr_data
);
    // Purpose: data offered to the bank in a load step.
    always_comb wr_data = inj_en ? ext_bus_in : latch_q;

    // Purpose: latch update rules per operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (op == OP_DRIVE)
            latch_q <= rd_data;
        else if (op == OP_LOAD && inj_en)
            latch_q <= ext_bus_in;
    end
endmodule

// File: rtl/rtx_bus_datapath.sv
// Top: single-bus register transfer datapath.
// A move is made of a drive step and a load step.
// Assumes one control word per clock.
module rtx_bus_datapath
    import rtx_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int CW_W    = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic              inj_en,
    input  logic [DATA_W-1:0] ext_bus_in,
    output logic [DATA_W-1:0] bus_obs,
    output logic              err_illegal
);
    rtx_op_e           op;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] wr_data;

    rtx_ctrl_decode #(.SEL_W(SEL_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .op(op), .sel(sel), .err_q(err_illegal)
    );

    rtx_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(op == OP_LOAD), .sel(sel),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    rtx_bus_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .op(op), .inj_en(inj_en),
        .rd_data(rd_data), .ext_bus_in(ext_bus_in),
        .latch_q(bus_obs), .wr_data(wr_data)
    );
endmodule

// File: rtl/rtx_bus_datapath_chk.sv
// Checker: port-level properties of the datapath, bound to the top module.
module rtx_bus_datapath_chk #(
    parameter int DATA_W = 16,
    parameter int CW_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW_W-1:0]   ctrl_word,
    input logic              inj_en,
    input logic [DATA_W-1:0] ext_bus_in,
    input logic [DATA_W-1:0] bus_obs,
    input logic              err_illegal
);
    logic [1:0] flags;
    assign flags = ctrl_word[CW_W-1:CW_W-2];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (bus_obs == '0 && !err_illegal)); // R1
    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b10 && !inj_en) |=> $stable(bus_obs)); // R4
    AST_INJECT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b10 && inj_en) |=> bus_obs == $past(ext_bus_in)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00) |=> ($stable(bus_obs) && !err_illegal)); // R7
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b11) |=> (err_illegal && $stable(bus_obs))); // R8
    AST_LEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != 2'b11) |=> !err_illegal); // R8
endmodule

bind rtx_bus_datapath rtx_bus_datapath_chk #(.DATA_W(DATA_W), .CW_W(CW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .inj_en(inj_en),
    .ext_bus_in(ext_bus_in), .bus_obs(bus_obs), .err_illegal(err_illegal)
);

// File: tb/sim_rtx_bus_datapath.sv
// Bench: sweeps injection, every move pair, idle and illegal words against a model kept at requirement level.
module sim_rtx_bus_datapath;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    ctrl_word = 5'b0;
    logic          inj_en = 1'b0;
    logic [DW-1:0] ext_bus_in = '0;
    logic [DW-1:0] bus_obs;
    logic          err_illegal;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] m_reg [8];
    logic [DW-1:0] m_latch;
    logic          m_err;

    always #5 clk = ~clk;

    rtx_bus_datapath u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .inj_en(inj_en),
        .ext_bus_in(ext_bus_in), .bus_obs(bus_obs), .err_illegal(err_illegal)
    );

    function automatic logic [DW-1:0] pat(int i);
        return DW'(16'hA5C3 ^ (i * 16'h1357));
    endfunction

    task automatic check(string req);
        n_chk++;
        if (bus_obs !== m_latch || err_illegal !== m_err) begin
            n_fail++;
            $display("FAIL %s: bus_obs=%h err=%b expected bus_obs=%h err=%b",
                     req, bus_obs, err_illegal, m_latch, m_err);
        end
    endtask

    // Applies one control word, updates the model and checks after the edge.
    task automatic step(logic [4:0] cw, logic inj, logic [DW-1:0] ext, string req);
        @(negedge clk);
        ctrl_word = cw; inj_en = inj; ext_bus_in = ext;
        @(posedge clk);
        #1;
        m_err = 1'b0;
        case (cw[4:3])
            2'b01: m_latch = m_reg[cw[2:0]];
            2'b10: begin
                if (inj) m_latch = ext;
                m_reg[cw[2:0]] = inj ? ext : m_latch;
            end
            2'b11: m_err = 1'b1;
            default: ;
        endcase
        check(req);
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < 8; i++) step({2'b01, 3'(i)}, 1'b1, 16'hDEAD, req);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_latch = '0; m_err = 1'b0;
        repeat (3) @(posedge clk);
        #1; check("R1");
        @(negedge clk); rst_n = 1'b1;
        read_all("R1");
        // R5 / R2: inject a distinct value into each register.
        for (int i = 0; i < 8; i++) step({2'b10, 3'(i)}, 1'b1, pat(i), "R5");
        // R3 / R9: read each register back with garbage on the external input.
        read_all("R3_R9");
        // R6: every source and destination pair, then read back the destination.
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++) begin
                step({2'b10, 3'(s)}, 1'b1, pat(s * 8 + d + 11), "R5");
                step({2'b01, 3'(s)}, 1'b1, 16'hBEEF, "R6");
                step({2'b10, 3'(d)}, 1'b0, 16'hBEEF, "R6");
                step({2'b01, 3'(d)}, 1'b0, 16'h0F0F, "R6");
            end
        step(5'b01001, 1'b0, '0, "R6");
        step(5'b10101, 1'b0, '0, "R6");
        step(5'b01101, 1'b0, '0, "R6");
        // R7: idle words with injection asserted.
        for (int i = 0; i < 8; i++) step({2'b00, 3'(i)}, 1'b1, pat(i + 40), "R7");
        read_all("R7");
        // R8: illegal words, flag behavior, then confirm nothing changed.
        for (int i = 0; i < 8; i++) step({2'b11, 3'(i)}, 1'b1, pat(i + 50), "R8");
        step(5'b00000, 1'b0, '0, "R8");
        read_all("R8");
        // R4: load without injection after an idle step uses the held latch.
        step(5'b01011, 1'b0, '0, "R4");
        step(5'b00000, 1'b1, 16'h1234, "R4");
        step(5'b10110, 1'b0, 16'h4321, "R4");
        step(5'b01110, 1'b0, '0, "R4");
        // R1: reset again clears the bank.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_latch = '0; m_err = 1'b0;
        check("R1");
        @(negedge clk); rst_n = 1'b1;
        read_all("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule